// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is a 32-bit datapath in which every move of data crosses one shared bus. Each cycle an external sequencer presents a flat control word. Its output enables choose the one source that drives the bus: the register file read port, the immediate extender, the ALU or the memory read data. Its load strobes choose which destinations capture the bus value at the next rising clock edge. The destinations are the instruction latch, the memory address latch, the two ALU operand latches and the register file write port. A transfer such as "address latch gets program counter" therefore takes a single control word.

The register file has 32 general entries and one extra entry that holds the program counter. Its single port index is picked by a selector. The selector can take the first source, second source or destination field of the latched instruction, or it can take the fixed link index or the program-counter entry. The instruction fields, the opcode and a flag that shows the first operand latch is zero go back to the sequencer, so it can branch and dispatch. The external memory is seen only through the address latch, the bus value, a write strobe and a read-data input.

Top module: `sbus_datapath`

## Requirements
- R1: While reset is low, all four latches and every register file entry, the program counter included, are cleared to zero. They still read zero after reset is released and before any write.
- R2: The bus carries the value of the single enabled source, or zero when no source is enabled. A control word may enable at most one source.
- R3: With `reg_wr` high, the bus value is written at the clock edge into the entry picked by `reg_sel`. With `reg_oe` high, that entry drives the bus in the same cycle, and it keeps its value until it is written again.
- R4: Entry 0 always reads zero, and a write to it has no effect.
- R5: The `reg_sel` codes are: 0 = instruction bits [25:21], 1 = bits [20:16], 2 = bits [15:11], 3 = entry 31 (link), 4 = program-counter entry (a 33rd entry, separate from entries 0..31). Codes 5 to 7 select entry 0.
- R6: The instruction, address and operand latches each load the bus value at the edge when their strobe is set, and hold their value otherwise. `mem_addr` is the address latch.
- R7: With `imm_oe` high, the bus carries instruction bits [15:0]. These are sign-extended when `imm_sext` is 1 and zero-extended when it is 0.
- R8: With `alu_oe` high, the bus carries the ALU result for `alu_op` on operands A and B. The codes are 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 nor, 6 signed less-than (1/0), 7 unsigned less-than, and 8 A+4. Codes 10 to 15 give zero.
- R9: ALU code 9 forms a jump target from A[31:28], then B[25:0], then two zero bits.
- R10: With `mem_oe` high, the bus carries `mem_rdata`. `mem_we` follows `mem_wr`, and `mem_wdata` carries the bus value.
- R11: The status outputs are the instruction fields opcode [31:26], [25:21], [20:16], [15:11], shift [10:6] and function [5:0]. `a_zero` is 1 exactly when operand latch A holds zero.
- R12: A latch or entry that is loaded from a bus value computed from its own contents captures the result based on its value before the edge. For example, A loaded with A+4 twice advances by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_ir | input | 1 | Load instruction latch from bus |
| ld_mar | input | 1 | Load memory address latch from bus |
| ld_opa | input | 1 | Load operand latch A from bus |
| ld_opb | input | 1 | Load operand latch B from bus |
| reg_sel | input | 3 | Register port index selector |
| reg_wr | input | 1 | Write bus value into selected entry |
| reg_oe | input | 1 | Selected entry drives the bus |
| imm_sext | input | 1 | 1 = sign-extend immediate, 0 = zero-extend |
| imm_oe | input | 1 | Extended immediate drives the bus |
| alu_op | input | 4 | ALU function code |
| alu_oe | input | 1 | ALU result drives the bus |
| mem_wr | input | 1 | Memory write strobe request |
| mem_oe | input | 1 | Memory read data drives the bus |
| mem_rdata | input | 32 | Data returned by memory |
| bus_data | output | 32 | Current bus value |
| mem_addr | output | 32 | Memory address latch |
| mem_wdata | output | 32 | Write data to memory (bus value) |
| mem_we | output | 1 | Write strobe to memory |
| fld_op | output | 6 | Opcode field of instruction latch |
| fld_rs | output | 5 | First source field |
| fld_rt | output | 5 | Second source field |
| fld_rd | output | 5 | Destination field |
| fld_sh | output | 5 | Shift amount field |
| fld_fn | output | 6 | Function field |
| a_zero | output | 1 | Operand latch A equals zero |

## Verification
The hardest states to reach from the ports are those in which the register index comes from the instruction latch and lands on entry 0 or entry 31. To reach them, the stimulus first loads an instruction word whose source fields are 0 and 31 through the memory read path. It then writes through the field selectors and reads the same entries back through both the field and the fixed link selectors. Self-referencing updates, where A is loaded with A+4, are driven on back-to-back cycles to show that the value before the edge is the one used.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    // register port index selector codes
    typedef enum logic [2:0] {
        SEL_RS   = 3'd0,
        SEL_RT   = 3'd1,
        SEL_RD   = 3'd2,
        SEL_LINK = 3'd3,
        SEL_PC   = 3'd4
    } rsel_e;

    // ALU function codes
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOR  = 4'd5,
        OP_SLT  = 4'd6,
        OP_SLTU = 4'd7,
        OP_INC4 = 4'd8,
        OP_JTGT = 4'd9
    } aluop_e;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
    parameter int DATA_W = 32,
    parameter int NGPR   = 32,
    parameter int IDX_W  = $clog2(NGPR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int NENT = NGPR + 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NGPR);

    logic [DATA_W-1:0] rf_d [NENT];
    logic [DATA_W-1:0] rf_q [NENT];
    logic              idx_live;

    // entry 0 and out-of-range indices are dead
    assign idx_live = (idx != '0) && (idx <= TOP_IDX);

    always_comb begin
        rf_d = rf_q;
        if (we && idx_live) begin
            rf_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '{default: '0};
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata = idx_live ? rf_q[idx] : '0;

    // R3
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx != '0 && idx <= TOP_IDX) |=> (rf_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/sbus_immext.sv
module sbus_immext #(
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              sext,
    output logic [DATA_W-1:0] ext
);

    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        if (sext) begin
            ext = {{PAD_W{imm[IMM_W-1]}}, imm};
        end else begin
            ext = {{PAD_W{1'b0}}, imm};
        end
    end

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TGT_W  = 26
) (
    input  aluop_e            op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam int HI_W = DATA_W - TGT_W - 2;

    logic lt_s;
    logic lt_u;

    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_SLT:  y = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU: y = {{(DATA_W-1){1'b0}}, lt_u};
            OP_INC4: y = a + DATA_W'(4);
            OP_JTGT: y = {a[DATA_W-1 -: HI_W], b[TGT_W-1:0], 2'b00};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NGPR     = 32,
    parameter int IMM_W    = 16,
    parameter int OPC_W    = 6,
    parameter int FLD_W    = 5,
    parameter int FN_W     = 6,
    parameter int LINK_IDX = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_ir,
    input  logic              ld_mar,
    input  logic              ld_opa,
    input  logic              ld_opb,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_oe,
    input  logic              imm_sext,
    input  logic              imm_oe,
    input  logic [3:0]        alu_op,
    input  logic              alu_oe,
    input  logic              mem_wr,
    input  logic              mem_oe,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       bus_data,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              mem_we,
    output logic [5:0]        fld_op,
    output logic [4:0]        fld_rs,
    output logic [4:0]        fld_rt,
    output logic [4:0]        fld_rd,
    output logic [4:0]        fld_sh,
    output logic [5:0]        fld_fn,
    output logic              a_zero
);

    localparam int IDX_W  = $clog2(NGPR + 1);
    localparam int RS_LSB = DATA_W - OPC_W - FLD_W;
    localparam int RT_LSB = RS_LSB - FLD_W;
    localparam int RD_LSB = RT_LSB - FLD_W;
    localparam int SH_LSB = RD_LSB - FLD_W;
    localparam int TGT_W  = DATA_W - OPC_W;
    localparam int HI_W   = DATA_W - TGT_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] mar;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
    } lat_t;

    lat_t              lat_d;
    lat_t              lat_q;
    logic [IDX_W-1:0]  rf_idx;
    logic [DATA_W-1:0] rf_rdata;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] bus_w;
    logic              any_src;

    // register port index decode
    always_comb begin
        case (rsel_e'(reg_sel))
            SEL_RS:   rf_idx = IDX_W'(lat_q.ir[RS_LSB +: FLD_W]);
            SEL_RT:   rf_idx = IDX_W'(lat_q.ir[RT_LSB +: FLD_W]);
            SEL_RD:   rf_idx = IDX_W'(lat_q.ir[RD_LSB +: FLD_W]);
            SEL_LINK: rf_idx = IDX_W'(LINK_IDX);
            SEL_PC:   rf_idx = IDX_W'(NGPR);
            default:  rf_idx = '0;
        endcase
    end

    sbus_regfile #(
        .DATA_W (DATA_W),
        .NGPR   (NGPR),
        .IDX_W  (IDX_W)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (rf_idx),
        .we    (reg_wr),
        .wdata (bus_w),
        .rdata (rf_rdata)
    );

    sbus_immext #(
        .IMM_W  (IMM_W),
        .DATA_W (DATA_W)
    ) u_imm (
        .imm  (lat_q.ir[IMM_W-1:0]),
        .sext (imm_sext),
        .ext  (imm_ext)
    );

    sbus_alu #(
        .DATA_W (DATA_W),
        .TGT_W  (TGT_W)
    ) u_alu (
        .op (aluop_e'(alu_op)),
        .a  (lat_q.opa),
        .b  (lat_q.opb),
        .y  (alu_y)
    );

    // shared bus: gated sources merged, zero when idle
    assign any_src = reg_oe | imm_oe | alu_oe | mem_oe;

    always_comb begin
        bus_w = '0;
        if (reg_oe) bus_w = bus_w | rf_rdata;
        if (imm_oe) bus_w = bus_w | imm_ext;
        if (alu_oe) bus_w = bus_w | alu_y;
        if (mem_oe) bus_w = bus_w | mem_rdata;
    end

    // latch bank next state
    always_comb begin
        lat_d = lat_q;
        if (ld_ir)  lat_d.ir  = bus_w;
        if (ld_mar) lat_d.mar = bus_w;
        if (ld_opa) lat_d.opa = bus_w;
        if (ld_opb) lat_d.opb = bus_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign bus_data  = bus_w;
    assign mem_addr  = lat_q.mar;
    assign mem_wdata = bus_w;
    assign mem_we    = mem_wr;
    assign fld_op    = lat_q.ir[DATA_W-1 -: OPC_W];
    assign fld_rs    = lat_q.ir[RS_LSB +: FLD_W];
    assign fld_rt    = lat_q.ir[RT_LSB +: FLD_W];
    assign fld_rd    = lat_q.ir[RD_LSB +: FLD_W];
    assign fld_sh    = lat_q.ir[SH_LSB +: FLD_W];
    assign fld_fn    = lat_q.ir[FN_W-1:0];
    assign a_zero    = (lat_q.opa == '0);

    // R2
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_oe, imm_oe, alu_oe, mem_oe}) <= 1);

    // R2
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_src |-> (bus_data == '0));

    // R6
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ir |=> $stable(fld_op) && $stable(fld_rs) && $stable(fld_fn));

    // R6
    mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mar |=> (mem_addr == $past(bus_data)));

    // R7
    sext_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_oe && imm_sext) |->
            (($countones(bus_data[DATA_W-1:IMM_W-1]) == 0) ||
             ($countones(bus_data[DATA_W-1:IMM_W-1]) == DATA_W - IMM_W + 1)));

    // R9
    jtgt_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_oe && alu_op == 4'd9) |->
            (bus_data[1:0] == 2'b00 && bus_data[DATA_W-1 -: HI_W] == lat_q.opa[DATA_W-1 -: HI_W]));

    // R11
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_opa |=> (a_zero == ($past(bus_data) == '0)));

endmodule

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
module sim_sbus_datapath;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_ir, ld_mar, ld_opa, ld_opb;
    logic [2:0]  reg_sel;
    logic        reg_wr, reg_oe, imm_sext, imm_oe;
    logic [3:0]  alu_op;
    logic        alu_oe, mem_wr, mem_oe;
    logic [31:0] mem_rdata;
    logic [31:0] bus_data, mem_addr, mem_wdata;
    logic        mem_we;
    logic [5:0]  fld_op, fld_fn;
    logic [4:0]  fld_rs, fld_rt, fld_rd, fld_sh;
    logic        a_zero;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sbus_datapath u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_ir(ld_ir), .ld_mar(ld_mar), .ld_opa(ld_opa), .ld_opb(ld_opb),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_oe(reg_oe),
        .imm_sext(imm_sext), .imm_oe(imm_oe),
        .alu_op(alu_op), .alu_oe(alu_oe),
        .mem_wr(mem_wr), .mem_oe(mem_oe), .mem_rdata(mem_rdata),
        .bus_data(bus_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .fld_op(fld_op), .fld_rs(fld_rs), .fld_rt(fld_rt), .fld_rd(fld_rd),
        .fld_sh(fld_sh), .fld_fn(fld_fn), .a_zero(a_zero)
    );

    // control word bit layout used by the bench
    localparam logic [17:0] LDIR = 18'd1 << 17;
    localparam logic [17:0] LDM  = 18'd1 << 16;
    localparam logic [17:0] LDA  = 18'd1 << 15;
    localparam logic [17:0] LDB  = 18'd1 << 14;
    localparam logic [17:0] S_RS = 18'd0;
    localparam logic [17:0] S_RT = 18'd1 << 11;
    localparam logic [17:0] S_RD = 18'd2 << 11;
    localparam logic [17:0] S_LK = 18'd3 << 11;
    localparam logic [17:0] S_PC = 18'd4 << 11;
    localparam logic [17:0] S_5  = 18'd5 << 11;
    localparam logic [17:0] RWR  = 18'd1 << 10;
    localparam logic [17:0] ROE  = 18'd1 << 9;
    localparam logic [17:0] SX   = 18'd1 << 8;
    localparam logic [17:0] IOE  = 18'd1 << 7;
    localparam logic [17:0] AOE  = 18'd1 << 2;
    localparam logic [17:0] MWR  = 18'd1 << 1;
    localparam logic [17:0] MOE  = 18'd1;
    localparam logic [17:0] O_SUB  = 18'd1 << 3;
    localparam logic [17:0] O_AND  = 18'd2 << 3;
    localparam logic [17:0] O_OR   = 18'd3 << 3;
    localparam logic [17:0] O_XOR  = 18'd4 << 3;
    localparam logic [17:0] O_NOR  = 18'd5 << 3;
    localparam logic [17:0] O_SLT  = 18'd6 << 3;
    localparam logic [17:0] O_SLTU = 18'd7 << 3;
    localparam logic [17:0] O_INC  = 18'd8 << 3;
    localparam logic [17:0] O_JT   = 18'd9 << 3;
    localparam logic [17:0] O_12   = 18'd12 << 3;

    typedef struct packed {
        logic [17:0] c;
        logic [31:0] rd;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{18'd0,             32'h0,        1'b1, 32'h0,        4'd2},  // R2 idle bus
        '{ROE|S_PC,          32'h0,        1'b1, 32'h0,        4'd1},  // R1 pc cleared
        '{MOE|LDIR,          32'h8C658004, 1'b1, 32'h8C658004, 4'd10}, // R10
        '{MOE|RWR|S_RS,      32'h12345678, 1'b1, 32'h12345678, 4'd3},  // R3 r3
        '{MOE|RWR|S_RT,      32'hFFFFFFF0, 1'b1, 32'hFFFFFFF0, 4'd3},  // R3 r5
        '{ROE|S_RS|LDA,      32'h0,        1'b1, 32'h12345678, 4'd5},  // R5 rs field
        '{ROE|S_RT|LDB,      32'h0,        1'b1, 32'hFFFFFFF0, 4'd5},  // R5 rt field
        '{AOE,               32'h0,        1'b1, 32'h12345668, 4'd8},  // R8 add
        '{AOE|O_SUB,         32'h0,        1'b1, 32'h12345688, 4'd8},  // R8
        '{AOE|O_AND,         32'h0,        1'b1, 32'h12345670, 4'd8},  // R8
        '{AOE|O_OR,          32'h0,        1'b1, 32'hFFFFFFF8, 4'd8},  // R8
        '{AOE|O_XOR,         32'h0,        1'b1, 32'hEDCBA988, 4'd8},  // R8
        '{AOE|O_NOR,         32'h0,        1'b1, 32'h00000007, 4'd8},  // R8
        '{AOE|O_SLT,         32'h0,        1'b1, 32'h0,        4'd8},  // R8 signed
        '{AOE|O_SLTU,        32'h0,        1'b1, 32'h1,        4'd8},  // R8 unsigned
        '{AOE|O_12,          32'h0,        1'b1, 32'h0,        4'd8},  // R8 unused code
        '{IOE|SX,            32'h0,        1'b1, 32'hFFFF8004, 4'd7},  // R7 sign
        '{IOE,               32'h0,        1'b1, 32'h00008004, 4'd7},  // R7 zero
        '{AOE|O_JT,          32'h0,        1'b1, 32'h1FFFFFC0, 4'd9},  // R9
        '{AOE|O_INC|RWR|S_PC,32'h0,        1'b1, 32'h1234567C, 4'd8},  // R8 a+4 into pc
        '{ROE|S_PC|LDM,      32'h0,        1'b1, 32'h1234567C, 4'd6},  // R6 mar from pc
        '{MOE|RWR|S_RD,      32'hA5A5A5A5, 1'b1, 32'hA5A5A5A5, 4'd5},  // R5 rd field (16)
        '{MOE|RWR|S_LK,      32'h0BADF00D, 1'b1, 32'h0BADF00D, 4'd5},  // R5 link
        '{ROE|S_RD,          32'h0,        1'b1, 32'hA5A5A5A5, 4'd5},  // R5
        '{ROE|S_LK,          32'h0,        1'b1, 32'h0BADF00D, 4'd5},  // R5
        '{ROE|S_RT,          32'h0,        1'b1, 32'hFFFFFFF0, 4'd3}   // R3 held
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [17:0] c, input logic [31:0] rd);
        {ld_ir, ld_mar, ld_opa, ld_opb, reg_sel, reg_wr, reg_oe,
         imm_sext, imm_oe, alu_op, alu_oe, mem_wr, mem_oe} = c;
        mem_rdata = rd;
        // R2: bench flags any control word with more than one bus source
        if ($countones({c[9], c[7], c[2], c[0]}) > 1) begin
            total++;
            bad++;
            $display("FAIL R2 sources act=%0d exp=1", $countones({c[9], c[7], c[2], c[0]}));
        end
    endtask

    task automatic cyc(input logic [17:0] c, input logic [31:0] rd);
        @(negedge clk);
        drive(c, rd);
        #1;
    endtask

    function automatic void summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endfunction

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(18'd0, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        check("R1 mar reset", mem_addr, 32'h0);
        check("R1 ir reset", 32'(fld_op), 32'h0);
        check("R1 a reset", 32'(a_zero), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i].c, VT[i].rd);
            #1;
            if (VT[i].chk) begin
                check($sformatf("R%0d vec%0d", VT[i].rq, i), bus_data, VT[i].exp);
            end
        end

        cyc(18'd0, 32'h0);
        check("R6 mem_addr", mem_addr, 32'h1234567C);
        check("R11 op", 32'(fld_op), 32'h23);
        check("R11 rs", 32'(fld_rs), 32'd3);
        check("R11 rt", 32'(fld_rt), 32'd5);
        check("R11 rd", 32'(fld_rd), 32'd16);
        check("R11 sh", 32'(fld_sh), 32'd0);
        check("R11 fn", 32'(fld_fn), 32'd4);
        check("R11 a_zero low", 32'(a_zero), 32'h0);

        // instruction with first source 0 and second source 31
        cyc(MOE|LDIR, 32'h001F0000);
        check("R10 ir via mem", bus_data, 32'h001F0000);
        cyc(MOE|RWR|S_RS, 32'hDEADBEEF);
        cyc(ROE|S_RS|LDA, 32'h0);
        check("R4 entry0 zero", bus_data, 32'h0);
        cyc(ROE|S_RT, 32'h0);
        check("R5 rt=31 is link", bus_data, 32'h0BADF00D);
        check("R11 a_zero high", 32'(a_zero), 32'h1);

        cyc(MOE|RWR|S_5, 32'h00000055);
        cyc(ROE|S_5, 32'h0);
        check("R5 code5 reads zero", bus_data, 32'h0);
        cyc(ROE|S_PC, 32'h0);
        check("R5 pc untouched", bus_data, 32'h1234567C);

        cyc(MOE|LDA, 32'h00000010);
        cyc(AOE|O_INC|LDA, 32'h0);
        check("R12 a+4 first", bus_data, 32'h00000014);
        cyc(AOE|O_INC, 32'h0);
        check("R12 a+4 second", bus_data, 32'h00000018);

        cyc(ROE|S_LK|MWR, 32'h0);
        check("R10 we", 32'(mem_we), 32'h1);
        check("R10 wdata", mem_wdata, 32'h0BADF00D);
        check("R6 mar held", mem_addr, 32'h1234567C);
        cyc(18'd0, 32'h0);
        check("R10 we low", 32'(mem_we), 32'h0);
        check("R2 idle", bus_data, 32'h0);

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mar cleared", mem_addr, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(ROE|S_PC, 32'h0);
        check("R1 pc cleared", bus_data, 32'h0);
        cyc(ROE|S_LK, 32'h0);
        check("R1 link cleared", bus_data, 32'h0);
        cyc(18'd0, 32'h0);

        summary();
        $finish;
    end

endmodule